// File: doc/BRIEF.md
# Power-Good Delay Sequencer

This block turns the state of two supply rails into one active-high power-good signal that the rest of the chip uses as its release from power-on reset. Each rail reports two digital flags from outside comparators: one that is high when the rail is above its valid level, and one that is high when the rail has sagged below its ineffective level. All four flags are asynchronous to the block's clock and pass through two-flop synchronizers before any decision uses them.

Once both rails read valid, the block counts millisecond ticks in two stages. The base stage has a long or a short length, chosen by one configuration bit. The extra stage follows it, with one of four lengths chosen by a two-bit field. The output rises only when the extra stage ends. The configuration is captured at the moment counting starts. If either rail stops reading valid during the count, the count is abandoned and must start again from zero. When both rails read below their ineffective levels, the output falls at once from any state. All lengths are parameters counted in ticks, so a bench can shorten them.

Top module: `pwrgood_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pwr_good` is low.
- R2: After both synchronized valid flags are high, `pwr_good` rises on the clock edge that samples the Nth `ms_tick` pulse received after counting began. N is the base length plus the extra length. It does not rise after N-1 pulses.
- R3: The base length is `BASE_LONG` ticks when `cfg_short` is 0 and `BASE_SHORT` ticks when `cfg_short` is 1.
- R4: The extra length for `cfg_extra` values 0, 1, 2 and 3 is `EXTRA_0`, `EXTRA_1`, `EXTRA_2` and `EXTRA_3` ticks, in that order. With a zero extra length, the output rises straight at the end of the base stage.
- R5: When both `*_low` flags are high, `pwr_good` is low three clock edges after the flags change: two edges in the synchronizer and one in the state register. This holds from any state.
- R6: When the output is high and only one rail reports low, or a rail's valid flag drops without both rails reporting low, `pwr_good` stays high.
- R7: If either valid flag drops during counting, the count is discarded and the output stays low. Once both flags are valid again, a full N ticks are needed.
- R8: `cfg_short` and `cfg_extra` are sampled when counting starts. A change while counting does not alter that delay.
- R9: `ms_tick` pulses that arrive while the two rails are not both valid are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rail_a_ok | input | 1 | Rail A above its valid level (async) |
| rail_a_low | input | 1 | Rail A below its ineffective level (async) |
| rail_b_ok | input | 1 | Rail B above its valid level (async) |
| rail_b_low | input | 1 | Rail B below its ineffective level (async) |
| cfg_short | input | 1 | 1 selects the short base length |
| cfg_extra | input | 2 | Selects one of four extra lengths |
| pwr_good | output | 1 | Power-good output, active high |

## Verification
A rail change reaches the counting logic after two edges. So the bench waits four cycles after it sets the rails valid before it sends any tick. Each tick is one cycle high followed by one low cycle, and the bench samples `pwr_good` at the falling edge after that low cycle, when the state register has already taken the tick. For the fall, the bench samples at the falling edge after the second rising edge, where the output must still be high, and again after the third, where it must be low. That pins the fall to exactly three edges. Random configurations, random abort points and configuration changes in the middle of a count are checked against a bench function that adds the base and extra lengths.

// File: rtl/pwrgood_seq.sv
module pwrgood_seq #(
  parameter int BASE_LONG  = 400,
  parameter int BASE_SHORT = 250,
  parameter int EXTRA_0    = 0,
  parameter int EXTRA_1    = 50,
  parameter int EXTRA_2    = 100,
  parameter int EXTRA_3    = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       rail_a_ok,
  input  logic       rail_a_low,
  input  logic       rail_b_ok,
  input  logic       rail_b_low,
  input  logic       cfg_short,
  input  logic [1:0] cfg_extra,
  output logic       pwr_good
);

  localparam int MAX_B  = (BASE_LONG > BASE_SHORT) ? BASE_LONG : BASE_SHORT;
  localparam int MAX_E01 = (EXTRA_0 > EXTRA_1) ? EXTRA_0 : EXTRA_1;
  localparam int MAX_E23 = (EXTRA_2 > EXTRA_3) ? EXTRA_2 : EXTRA_3;
  localparam int MAX_E  = (MAX_E01 > MAX_E23) ? MAX_E01 : MAX_E23;
  localparam int MAX_ALL = (MAX_B > MAX_E) ? MAX_B : MAX_E;
  localparam int CW = $clog2(MAX_ALL + 1);

  typedef enum logic [1:0] {S_IDLE, S_BASE, S_EXTRA, S_ON} st_t;
  st_t st;

  logic [1:0] a_ok_q, a_low_q, b_ok_q, b_low_q;
  logic [CW-1:0] cnt, base_lim, extra_lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_ok_q <= '0; a_low_q <= '0; b_ok_q <= '0; b_low_q <= '0;
    end else begin
      a_ok_q  <= {a_ok_q[0],  rail_a_ok};
      a_low_q <= {a_low_q[0], rail_a_low};
      b_ok_q  <= {b_ok_q[0],  rail_b_ok};
      b_low_q <= {b_low_q[0], rail_b_low};
    end
  end

  wire both_ok  = a_ok_q[1] & b_ok_q[1];
  wire both_low = a_low_q[1] & b_low_q[1];

  logic [CW-1:0] sel_base, sel_extra;
  assign sel_base = cfg_short ? CW'(BASE_SHORT) : CW'(BASE_LONG);
  always_comb begin
    case (cfg_extra)
      2'd0:    sel_extra = CW'(EXTRA_0);
      2'd1:    sel_extra = CW'(EXTRA_1);
      2'd2:    sel_extra = CW'(EXTRA_2);
      default: sel_extra = CW'(EXTRA_3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cnt <= '0;
      base_lim <= '0;
      extra_lim <= '0;
    end else if (both_low) begin
      st <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (both_ok) begin
            st <= S_BASE;
            base_lim <= sel_base;
            extra_lim <= sel_extra;
          end
        end
        S_BASE: begin
          if (!both_ok) begin
            st <= S_IDLE;
            cnt <= '0;
          end else if (ms_tick) begin
            if (cnt == base_lim - 1'b1) begin
              cnt <= '0;
              st <= (extra_lim == '0) ? S_ON : S_EXTRA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_EXTRA: begin
          if (!both_ok) begin
            st <= S_IDLE;
            cnt <= '0;
          end else if (ms_tick) begin
            if (cnt == extra_lim - 1'b1) begin
              cnt <= '0;
              st <= S_ON;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_ON;
      endcase
    end
  end

  assign pwr_good = (st == S_ON);

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !pwr_good);

  a_r5_drop_now: assert property (@(posedge clk) disable iff (rst)
    both_low |=> !pwr_good);

  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good) |-> $past(ms_tick) && $past(both_ok));

  a_r7_abort: assert property (@(posedge clk) disable iff (rst)
    ((st == S_BASE || st == S_EXTRA) && !both_ok) |=> st == S_IDLE);

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(base_lim) && $stable(extra_lim));

  a_r3_base_bound: assert property (@(posedge clk) disable iff (rst)
    (st == S_BASE) |-> cnt < base_lim);

  a_r6_hold_on: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && !both_low) |=> pwr_good);

endmodule

// File: tb/pwrgood_seq_test.sv
module pwrgood_seq_test;
  localparam int BL = 8, BS = 5, E0 = 0, E1 = 2, E2 = 3, E3 = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic a_ok = 1'b0, a_low = 1'b1, b_ok = 1'b0, b_low = 1'b1;
  logic cfg_short = 1'b0;
  logic [1:0] cfg_extra = 2'd0;
  logic pwr_good;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwrgood_seq #(.BASE_LONG(BL), .BASE_SHORT(BS), .EXTRA_0(E0), .EXTRA_1(E1),
                .EXTRA_2(E2), .EXTRA_3(E3)) uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .rail_a_ok(a_ok), .rail_a_low(a_low), .rail_b_ok(b_ok), .rail_b_low(b_low),
    .cfg_short(cfg_short), .cfg_extra(cfg_extra), .pwr_good(pwr_good));

  function automatic int exp_delay(input bit s, input logic [1:0] e);
    int b, x;
    b = s ? BS : BL;
    case (e)
      2'd0: x = E0;
      2'd1: x = E1;
      2'd2: x = E2;
      default: x = E3;
    endcase
    return b + x;
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pwr_good=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; @(negedge clk);
      ms_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic rails(input logic av, input logic al, input logic bv, input logic bl);
    a_ok = av; a_low = al; b_ok = bv; b_low = bl;
  endtask

  task automatic power_down();
    rails(1'b0, 1'b1, 1'b0, 1'b1);
    cycles(4);
  endtask

  task automatic full_run(input bit s, input logic [1:0] e, input string req);
    int n;
    n = exp_delay(s, e);
    cfg_short = s; cfg_extra = e;
    rails(1'b1, 1'b0, 1'b1, 1'b0);
    cycles(4);
    ticks(n - 1);
    chk(pwr_good, 1'b0, req);
    ticks(1);
    chk(pwr_good, 1'b1, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cycles(2);
    chk(pwr_good, 1'b0, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(pwr_good, 1'b0, "R1 after reset");

    // R3 / R4: every base and extra combination
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 4; e++) begin
        full_run(s[0], e[1:0], "R2 R3 R4 delay");
        power_down();
      end

    // R5: exact fall timing and R6 partial drops
    full_run(1'b0, 2'd1, "R2");
    rails(1'b0, 1'b1, 1'b1, 1'b0);
    cycles(6);
    chk(pwr_good, 1'b1, "R6 one rail low");
    rails(1'b0, 1'b0, 1'b0, 1'b0);
    cycles(6);
    chk(pwr_good, 1'b1, "R6 valid gone no low");
    rails(1'b0, 1'b1, 1'b0, 1'b1);
    cycles(2);
    chk(pwr_good, 1'b1, "R5 still high after two edges");
    cycles(1);
    chk(pwr_good, 1'b0, "R5 low after three edges");
    cycles(2);

    // R5 from mid-count
    cfg_short = 1'b1; cfg_extra = 2'd3;
    rails(1'b1, 1'b0, 1'b1, 1'b0);
    cycles(4);
    ticks(BS + 1);
    rails(1'b0, 1'b1, 1'b0, 1'b1);
    cycles(3);
    chk(pwr_good, 1'b0, "R5 from extra stage");
    ticks(20);
    chk(pwr_good, 1'b0, "R9 ticks while down");
    full_run(1'b1, 2'd3, "R9 full count after idle ticks");
    power_down();

    // R9: ticks with only one rail valid
    rails(1'b1, 1'b0, 1'b0, 1'b0);
    cycles(4);
    ticks(30);
    chk(pwr_good, 1'b0, "R9 one rail valid");
    full_run(1'b0, 2'd0, "R9 count from zero");
    power_down();

    // random: aborts and mid-count config changes
    for (int it = 0; it < 40; it++) begin
      bit s;
      logic [1:0] e;
      int n, k;
      s = $urandom_range(0, 1);
      e = 2'($urandom_range(0, 3));
      n = exp_delay(s, e);
      cfg_short = s; cfg_extra = e;
      rails(1'b1, 1'b0, 1'b1, 1'b0);
      cycles(4);
      if ($urandom_range(0, 1) == 1) begin
        k = $urandom_range(1, n - 1);
        ticks(k);
        if ($urandom_range(0, 1) == 1) a_ok = 1'b0; else b_ok = 1'b0;
        cycles(4);
        ticks(3);
        chk(pwr_good, 1'b0, "R7 aborted count");
        rails(1'b1, 1'b0, 1'b1, 1'b0);
        cycles(4);
      end
      k = $urandom_range(0, n - 1);
      ticks(k);
      cfg_short = $urandom_range(0, 1);
      cfg_extra = 2'($urandom_range(0, 3));
      ticks(n - 1 - k);
      chk(pwr_good, 1'b0, "R8 R7 one tick short");
      ticks(1);
      chk(pwr_good, 1'b1, "R8 R7 rise at start config");
      power_down();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule